// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block is a clocked target on a Low Pin Count bus. It watches a 4-bit multiplexed nibble bus with an active-low frame strobe, recognises memory read and memory write cycles, and collects the 32-bit address one nibble per clock. It then decides whether the cycle belongs to it. A cycle is claimed when the address lies in the block's own 512 KB window, which is chosen by a 3-bit strap, or when it hits a single read-only byte that reports five general-purpose input pins. Cycles that are not claimed leave the bus undriven.

On the back side the block presents a byte-wide port to a memory array. The port carries an address, a read strobe, a write strobe, write data and read data, plus a busy input. While busy is high, the block stretches the sync field with long-wait codes. This lets a slow array hold the host off without any buffering inside the target. If the frame strobe falls with a start nibble at any point, the cycle in progress is abandoned and decoding begins again.

Top module: `lpc_mem_target`

## Requirements
- R1: A start is the frame strobe low with nibble 0000b. On the next clock the cycle-type nibble selects the cycle: bits 3:1 = 010b is a memory read, 011b is a memory write, and bit 0 is ignored. Any other type ends the cycle, and the bus is not driven.
- R2: The address arrives in 8 consecutive nibbles, bits 31:28 first and bits 3:0 last. `mem_addr` carries address bits 18:0 of the claimed cycle.
- R3: A memory cycle is claimed only when address bits 31:22 are all ones and address bits 21:19 equal the bitwise inverse of `id_strap`. Strap 000 therefore owns FFF80000h–FFFFFFFFh. For an unclaimed cycle, `lad_oe`, `mem_re` and `mem_we` stay low.
- R4: For a claimed read, the bus stays released during the two turnaround clocks that follow the last address nibble. The target drives the sync field from the third clock onward, and `mem_re` is high during the sync clocks.
- R5: The sync nibble is 0110b (long wait) on every sync clock in which a memory access sees `mem_busy` high. It is 0000b (ready) on the first clock in which `mem_busy` is low.
- R6: After a ready sync of a read, the target drives the low data nibble and then the high data nibble. On the following clock it releases the bus.
- R7: For a claimed write, the host sends the low data nibble and then the high data nibble. `mem_we` is high for exactly the next clock, carrying the address and the assembled byte. Two turnaround clocks follow, and then the sync field is driven (per R5), after which the bus is released.
- R8: The general-purpose input byte is at address FFB0E100h with `id_strap` placed in bits 18:16. A read returns 000b in bits 7:5 and the `gpi` pins in bits 4:0. Its sync is ready at once, whatever the state of `mem_busy`, and `mem_re` stays low.
- R9: A write to the general-purpose input address is acknowledged with a ready sync, but it raises no `mem_we`.
- R10: The frame strobe low with 0000b in any state restarts the cycle and releases the bus on the next clock. The frame strobe low with any other nibble abandons the cycle.
- R11: While reset is asserted and after it is released, `lad_oe`, `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_strap | input | 3 | Strap selecting the window and the register address |
| gpi | input | 5 | General-purpose input pins, passed through on read |
| frame_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | Nibble bus as seen by the target |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Enable for `lad_out` onto the bus |
| mem_addr | output | 19 | Array byte address |
| mem_re | output | 1 | Array read strobe, high during read sync clocks |
| mem_we | output | 1 | Array write strobe, one clock per write |
| mem_wdata | output | 8 | Array write byte |
| mem_rdata | input | 8 | Array read byte, valid when `mem_busy` is low |
| mem_busy | input | 1 | Array not ready; stretches sync with wait codes |

## Verification
The bench builds the block with its default parameters: a 19-bit array address and a 3-bit strap. With these values it can sweep every strap against every one of the eight candidate windows, and every strap against every register-address variant, which covers all 64 pairings of each decoder. Wait-state depths from zero to three clocks, both values of the don't-care type bit, unsupported cycle types and restarts at several points of a cycle are exercised against the same arithmetic expectations for the read data.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  localparam int NIB_W      = 4;
  localparam int BUS_ADDR_W = 32;
  localparam int ADDR_NIBS  = BUS_ADDR_W / NIB_W;
  localparam int CNT_W      = $clog2(ADDR_NIBS);

  localparam logic [NIB_W-1:0] NIB_START  = 4'b0000;
  localparam logic [2:0]       CT_MEM_RD  = 3'b010;
  localparam logic [2:0]       CT_MEM_WR  = 3'b011;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_LWAIT = 4'b0110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_RTAR1,
    ST_RTAR2,
    ST_RSYNC,
    ST_RDLO,
    ST_RDHI,
    ST_WDLO,
    ST_WDHI,
    ST_WTAR1,
    ST_WTAR2,
    ST_WSYNC
  } lpc_state_e;

  function automatic logic is_sync(lpc_state_e s);
    return (s == ST_RSYNC) || (s == ST_WSYNC);
  endfunction

  function automatic logic target_drives(lpc_state_e s);
    return is_sync(s) || (s == ST_RDLO) || (s == ST_RDHI);
  endfunction

endpackage

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
  parameter int          ARR_W      = 19,
  parameter int          ID_W       = 3,
  parameter logic [31:0] GPI_BASE   = 32'hFFB0_E100,
  parameter int          GPI_ID_LSB = 16
) (
  input  logic [31:0]     addr,
  input  logic [ID_W-1:0] id,
  output logic            hit_mem,
  output logic            hit_gpi
);

  localparam int TOP_W = 32 - ARR_W - ID_W;

  function automatic logic mem_match(logic [31:0] a, logic [ID_W-1:0] s);
    return (&a[31 -: TOP_W]) && (a[ARR_W +: ID_W] == ~s);
  endfunction

  function automatic logic [31:0] gpi_addr(logic [ID_W-1:0] s);
    return GPI_BASE | ({{(32-ID_W){1'b0}}, s} << GPI_ID_LSB);
  endfunction

  always_comb begin
    hit_mem = mem_match(addr, id);
    hit_gpi = (addr == gpi_addr(id));
  end

endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ARR_W = 19,
  parameter int GPI_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [NIB_W-1:0]  lad_in,
  input  logic              hit_mem,
  input  logic              hit_gpi,
  input  logic [GPI_W-1:0]  gpi,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_busy,
  output lpc_state_e        state_o,
  output logic [31:0]       addr_full_o,
  output logic [ARR_W-1:0]  arr_addr_o,
  output logic [7:0]        data_o,
  output logic              sel_mem_o
);

  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIBS - 1);
  localparam int               SHIFT_W  = BUS_ADDR_W - NIB_W;

  lpc_state_e         state_q;
  logic [CNT_W-1:0]   nib_q;
  logic [SHIFT_W-1:0] addr_q;
  logic [7:0]         data_q;
  logic               wr_q;
  logic               sel_mem_q;
  logic [7:0]         gpi_byte;

  assign gpi_byte    = {{(8-GPI_W){1'b0}}, gpi};
  assign addr_full_o = {addr_q, lad_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      nib_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      wr_q      <= 1'b0;
      sel_mem_q <= 1'b0;
    end else if (!frame_n) begin
      state_q <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_q <= ST_IDLE;
        ST_CTYPE: begin
          nib_q <= '0;
          if (lad_in[3:1] == CT_MEM_RD) begin
            wr_q    <= 1'b0;
            state_q <= ST_ADDR;
          end else if (lad_in[3:1] == CT_MEM_WR) begin
            wr_q    <= 1'b1;
            state_q <= ST_ADDR;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_q <= {addr_q[SHIFT_W-NIB_W-1:0], lad_in};
          nib_q  <= nib_q + 1'b1;
          if (nib_q == LAST_NIB) begin
            if (hit_mem || hit_gpi) begin
              sel_mem_q <= hit_mem;
              state_q   <= wr_q ? ST_WDLO : ST_RTAR1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RTAR1: state_q <= ST_RTAR2;
        ST_RTAR2: state_q <= ST_RSYNC;
        ST_RSYNC: begin
          if (!sel_mem_q || !mem_busy) begin
            data_q  <= sel_mem_q ? mem_rdata : gpi_byte;
            state_q <= ST_RDLO;
          end
        end
        ST_RDLO: state_q <= ST_RDHI;
        ST_RDHI: state_q <= ST_IDLE;
        ST_WDLO: begin
          data_q[3:0] <= lad_in;
          state_q     <= ST_WDHI;
        end
        ST_WDHI: begin
          data_q[7:4] <= lad_in;
          state_q     <= ST_WTAR1;
        end
        ST_WTAR1: state_q <= ST_WTAR2;
        ST_WTAR2: state_q <= ST_WSYNC;
        ST_WSYNC: begin
          if (!sel_mem_q || !mem_busy) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign arr_addr_o = addr_q[ARR_W-1:0];
  assign data_o     = data_q;
  assign sel_mem_o  = sel_mem_q;

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_tgt_pkg::*;
(
  input  lpc_state_e       state,
  input  logic [7:0]       data,
  input  logic             sel_mem,
  input  logic             mem_busy,
  output logic [NIB_W-1:0] lad_out,
  output logic             lad_oe,
  output logic             in_sync,
  output logic             sync_wait
);

  always_comb begin
    in_sync   = is_sync(state);
    sync_wait = in_sync && sel_mem && mem_busy;
    lad_oe    = target_drives(state);
    unique case (state)
      ST_RSYNC, ST_WSYNC: lad_out = sync_wait ? SYNC_LWAIT : SYNC_READY;
      ST_RDLO:            lad_out = data[3:0];
      ST_RDHI:            lad_out = data[7:4];
      default:            lad_out = '0;
    endcase
  end

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ARR_W = 19,
  parameter int ID_W  = 3,
  parameter int GPI_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  id_strap,
  input  logic [GPI_W-1:0] gpi,
  input  logic             frame_n,
  input  logic [3:0]       lad_in,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  output logic [ARR_W-1:0] mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_busy
);

  lpc_state_e  state;
  logic [31:0] addr_full;
  logic [7:0]  data;
  logic        sel_mem;
  logic        hit_mem;
  logic        hit_gpi;
  logic        in_sync;
  logic        sync_wait;

  lpc_win_decode #(.ARR_W(ARR_W), .ID_W(ID_W)) u_decode (
    .addr    (addr_full),
    .id      (id_strap),
    .hit_mem (hit_mem),
    .hit_gpi (hit_gpi)
  );

  lpc_cycle_fsm #(.ARR_W(ARR_W), .GPI_W(GPI_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .lad_in      (lad_in),
    .hit_mem     (hit_mem),
    .hit_gpi     (hit_gpi),
    .gpi         (gpi),
    .mem_rdata   (mem_rdata),
    .mem_busy    (mem_busy),
    .state_o     (state),
    .addr_full_o (addr_full),
    .arr_addr_o  (mem_addr),
    .data_o      (data),
    .sel_mem_o   (sel_mem)
  );

  lpc_lad_drive u_drive (
    .state     (state),
    .data      (data),
    .sel_mem   (sel_mem),
    .mem_busy  (mem_busy),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .in_sync   (in_sync),
    .sync_wait (sync_wait)
  );

  // Array strobes: read held over the sync clocks, write for the clock after the high nibble.
  assign mem_re    = (state == ST_RSYNC) && sel_mem;
  assign mem_we    = (state == ST_WTAR1) && sel_mem;
  assign mem_wdata = data;

endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_in,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_we,
  input logic       mem_re,
  input logic       in_sync,
  input logic       sync_wait
);

  // R5: a waiting sync clock is followed by another sync clock unless the host restarts
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wait && frame_n |=> in_sync);

  // R5: only ready or long-wait codes appear in the sync field
  p_sync_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (lad_oe && (lad_out == 4'b0000 || lad_out == 4'b0110)));

  // R7: the write strobe lasts a single clock
  p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7: the write strobe falls in a turnaround clock, with the bus released
  p_we_bus_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !lad_oe);

  // R4: the read strobe is only seen while the target drives sync
  p_re_in_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (in_sync && lad_oe));

  // R10: a start nibble under a low frame releases the bus on the next clock
  p_restart_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n && lad_in == 4'b0000 |=> !lad_oe && !mem_we && !mem_re);

endmodule

bind lpc_mem_target lpc_mem_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_n   (frame_n),
  .lad_in    (lad_in),
  .lad_out   (lad_out),
  .lad_oe    (lad_oe),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .in_sync   (in_sync),
  .sync_wait (sync_wait)
);

// File: tb/test_lpc_mem_target.sv
module test_lpc_mem_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  id_strap = 3'd0;
  logic [4:0]  gpi = 5'd0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [18:0] mem_addr;
  logic        mem_re;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_busy = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  // Array model: byte is the low address byte mixed with address bits 18:11
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[18:11];

  lpc_mem_target i_lpc_mem_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_strap  (id_strap),
    .gpi       (gpi),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_busy  (mem_busy)
  );

  function automatic logic [7:0] arr_byte(logic [31:0] a);
    return a[7:0] ^ a[18:11];
  endfunction

  function automatic logic [31:0] win_addr(logic [2:0] w, logic [18:0] off);
    return {10'h3FF, ~w, off};
  endfunction

  function automatic logic [31:0] reg_addr(logic [2:0] s);
    return 32'hFFB0_E100 + (32'(s) * 32'h0001_0000);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Drive one nibble clock; returns at the next falling edge.
  task automatic send(input logic f, input logic [3:0] n);
    frame_n = f;
    lad_in  = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input logic ct_lsb, input int nb,
                    input bit hit, input bit reg_acc, input logic [7:0] d);
    send(1'b0, 4'h0);
    send(1'b1, {3'b010, ct_lsb});
    for (int i = 0; i < 8; i++) send(1'b1, a[31-4*i -: 4]);
    chk(!lad_oe, "R4 tar1", 32'(lad_oe), 0);
    send(1'b1, 4'hF);
    chk(!lad_oe, "R4 tar2", 32'(lad_oe), 0);
    send(1'b1, 4'hF);
    if (!hit) begin
      for (int i = 0; i < 3; i++) begin
        chk(!lad_oe && !mem_re && !mem_we, "R3 unclaimed", {lad_oe, mem_re, mem_we}, 0);
        send(1'b1, 4'hF);
      end
      return;
    end
    for (int i = 0; i < nb; i++) begin
      mem_busy = 1'b1;
      #1;
      chk(lad_oe && lad_out == 4'h6, "R5 wait", {lad_oe, lad_out}, 32'h16);
      send(1'b1, 4'hF);
    end
    mem_busy = reg_acc;
    #1;
    chk(lad_oe && lad_out == 4'h0, reg_acc ? "R8 ready" : "R5 ready", {lad_oe, lad_out}, 32'h10);
    chk(mem_re == !reg_acc, reg_acc ? "R8 no re" : "R4 re", 32'(mem_re), 32'(!reg_acc));
    if (!reg_acc) chk(mem_addr == a[18:0], "R2 addr", 32'(mem_addr), 32'(a[18:0]));
    send(1'b1, 4'hF);
    mem_busy = 1'b0;
    chk(lad_oe && lad_out == d[3:0], "R6 low", {lad_oe, lad_out}, {1'b1, d[3:0]});
    send(1'b1, 4'hF);
    chk(lad_oe && lad_out == d[7:4], "R6 high", {lad_oe, lad_out}, {1'b1, d[7:4]});
    send(1'b1, 4'hF);
    chk(!lad_oe, "R6 release", 32'(lad_oe), 0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d, input int nb,
                    input bit hit, input bit reg_acc);
    send(1'b0, 4'h0);
    send(1'b1, {3'b011, d[0]});
    for (int i = 0; i < 8; i++) send(1'b1, a[31-4*i -: 4]);
    send(1'b1, d[3:0]);
    send(1'b1, d[7:4]);
    if (hit && !reg_acc) begin
      chk(mem_we && mem_addr == a[18:0] && mem_wdata == d, "R7 strobe",
          {mem_we, mem_addr, mem_wdata}, {1'b1, a[18:0], d});
    end else begin
      chk(!mem_we, reg_acc ? "R9 no we" : "R3 no we", 32'(mem_we), 0);
    end
    chk(!lad_oe, "R7 tar", 32'(lad_oe), 0);
    send(1'b1, 4'hF);
    chk(!mem_we && !lad_oe, "R7 single", {mem_we, lad_oe}, 0);
    send(1'b1, 4'hF);
    if (!hit) begin
      chk(!lad_oe, "R3 write unclaimed", 32'(lad_oe), 0);
      send(1'b1, 4'hF);
      return;
    end
    for (int i = 0; i < nb; i++) begin
      mem_busy = 1'b1;
      #1;
      chk(lad_oe && lad_out == 4'h6, "R5 write wait", {lad_oe, lad_out}, 32'h16);
      send(1'b1, 4'hF);
    end
    mem_busy = reg_acc;
    #1;
    chk(lad_oe && lad_out == 4'h0, reg_acc ? "R9 ready" : "R7 ready", {lad_oe, lad_out}, 32'h10);
    send(1'b1, 4'hF);
    mem_busy = 1'b0;
    chk(!lad_oe, "R7 release", 32'(lad_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!lad_oe && !mem_re && !mem_we, "R11 in reset", {lad_oe, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    send(1'b1, 4'hF);
    chk(!lad_oe && !mem_re && !mem_we, "R11 after reset", {lad_oe, mem_re, mem_we}, 0);

    // R3 R2 R5 R6: every strap against every window, wait depth 0..2
    for (int s = 0; s < 8; s++) begin
      id_strap = 3'(s);
      for (int w = 0; w < 8; w++) begin
        logic [31:0] a;
        a = win_addr(3'(w), 19'((s * 8 + w) * 32'h2F1B3));
        rd(a, 1'(w), (s + w) % 3, w == s, 1'b0, arr_byte(a));
      end
      // R3: upper bits not all ones is never claimed
      rd({10'h3FE, ~3'(s), 19'h1ABCD}, 1'b0, 0, 1'b0, 1'b0, 8'h00);
    end

    // R8: every strap against every register address, busy held high
    for (int s = 0; s < 8; s++) begin
      id_strap = 3'(s);
      for (int j = 0; j < 8; j++) begin
        gpi = 5'(s * 5 + j * 3 + 1);
        rd(reg_addr(3'(j)), 1'b1, 0, j == s, 1'b1, {3'b000, gpi});
      end
    end

    // R7 R5: writes inside the window with 0..3 wait clocks
    id_strap = 3'd5;
    for (int k = 0; k < 4; k++) begin
      wr(win_addr(3'd5, 19'(32'h41230 + k * 32'h1111)), 8'(8'h3C + k * 8'h47), k, 1'b1, 1'b0);
    end
    // R3: write to a neighbouring window
    wr(win_addr(3'd4, 19'h00077), 8'hA5, 0, 1'b0, 1'b0);
    // R9: write to the register address, then read it back unchanged
    gpi = 5'h15;
    wr(reg_addr(3'd5), 8'hFF, 0, 1'b1, 1'b1);
    rd(reg_addr(3'd5), 1'b0, 0, 1'b1, 1'b1, 8'h15);

    // R1: unsupported cycle types drive nothing
    for (int t = 0; t < 4; t++) begin
      logic [3:0] ct;
      ct = (t == 0) ? 4'h0 : (t == 1) ? 4'h2 : (t == 2) ? 4'h8 : 4'hE;
      send(1'b0, 4'h0);
      send(1'b1, ct);
      for (int i = 0; i < 12; i++) begin
        chk(!lad_oe && !mem_re && !mem_we, "R1 other type", {lad_oe, mem_re, mem_we}, 0);
        send(1'b1, 4'hF);
      end
    end

    // R10: restart in the middle of the address field
    send(1'b0, 4'h0);
    send(1'b1, 4'h4);
    for (int i = 0; i < 3; i++) send(1'b1, 4'hF);
    rd(win_addr(3'd5, 19'h2468A), 1'b0, 1, 1'b1, 1'b0, arr_byte(win_addr(3'd5, 19'h2468A)));

    // R10: restart during a long wait releases the bus next clock
    send(1'b0, 4'h0);
    send(1'b1, 4'h4);
    for (int i = 0; i < 8; i++) send(1'b1, win_addr(3'd5, 19'h13579)[31-4*i -: 4]);
    send(1'b1, 4'hF);
    send(1'b1, 4'hF);
    mem_busy = 1'b1;
    send(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'h6, "R5 wait before restart", {lad_oe, lad_out}, 32'h16);
    send(1'b0, 4'h0);
    chk(!lad_oe, "R10 release", 32'(lad_oe), 0);
    mem_busy = 1'b0;
    send(1'b1, 4'h5);
    for (int i = 0; i < 8; i++) send(1'b1, win_addr(3'd5, 19'h0F0F0)[31-4*i -: 4]);
    send(1'b1, 4'hF);
    send(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'h0, "R10 restarted sync", {lad_oe, lad_out}, 32'h10);
    send(1'b1, 4'hF);
    chk(lad_out == arr_byte(win_addr(3'd5, 19'h0F0F0))[3:0], "R10 restarted data",
        32'(lad_out), 32'(arr_byte(win_addr(3'd5, 19'h0F0F0))[3:0]));
    send(1'b1, 4'hF);
    send(1'b1, 4'hF);

    // R10: frame low with a non-start nibble abandons the cycle
    send(1'b0, 4'h0);
    send(1'b1, 4'h4);
    send(1'b1, 4'hF);
    send(1'b0, 4'h3);
    for (int i = 0; i < 12; i++) begin
      chk(!lad_oe && !mem_re, "R10 abandon", {lad_oe, mem_re}, 0);
      send(1'b1, 4'hF);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule